// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the byte-shifting core of an SPI master. Software writes one transfer control word, which holds the clock mode, bit order, chip-select choice and polarity, and an optional software-owned chip-select level. When that word carries the go bit, the engine runs a burst. The burst length is the byte count presented on `burst_len` at the moment of the start. For each byte, the engine pops one entry from an external TX FIFO and shifts it out on `mosi` while it shifts in `miso`. It then pushes the received byte into an external RX FIFO.

An external clock divider supplies `half_tick`, which is one strobe per SPI half period. Every SPI clock edge, every chip-select set-up or hold interval, and every inter-byte gap is timed by that strobe. When the last byte is done, the engine pulses `xfer_done` for one cycle. On the same clock edge, the go bit reads back as zero. If the TX FIFO runs dry in the middle of a burst, the engine waits with the SPI clock parked at its idle level. It continues once data arrives.

Top module: `spi_xfer_engine`

## Requirements
- R1: A control write with bit 31 set starts a burst only when `cfg_enable` and `cfg_master` are both 1 and no burst is running. Otherwise the go bit stays 0, no FIFO entry is popped and no SPI clock edge occurs.
- R2: Bit 31 of `ctl_rdata` reads 1 from the cycle after an accepted start until the end of the burst. It reads 0 in the same cycle that the one-cycle `xfer_done` pulse is high.
- R3: A burst with byte count N pops exactly N TX entries, pushes exactly N RX bytes and gives exactly one `xfer_done` pulse. A count of 0 gives the pulse with no pop, no push and no SPI clock edge.
- R4: `sclk` rests at the polarity value in control bit 1 whenever no burst runs. Each byte takes exactly 16 `sclk` edges, and the clock returns to rest after every byte.
- R5: Control bit 0 selects the phase. When it is 0, data is captured on the first edge of each bit and changed on the second edge. When it is 1, data is changed on the first edge and captured on the second. Bytes exchange correctly in all four polarity/phase combinations.
- R6: Control bit 12 selects bit order: 1 sends and assembles the least significant bit first, and 0 puts the most significant bit first.
- R7: Control bits 5:4 select one of the four `cs_out` lines. Control bit 2 set makes chip select active low (the inactive level is 1); clear makes it active high. Every unselected line always sits at the inactive level.
- R8: With control bit 6 clear, the selected line goes active at least one `half_tick` before the first `sclk` edge. It stays active through every edge and inter-byte gap and through one further `half_tick` after the last edge. It returns to inactive in the cycle `xfer_done` is high.
- R9: With control bit 6 set, the selected line carries the raw value of control bit 7, independent of polarity and burst activity.
- R10: When the TX FIFO is empty and a byte is due, the engine does not pop. `sclk` stays at rest and the chip select stays active until data arrives, and then the burst completes normally.
- R11: Control writes made while a burst runs are ignored. After the burst, the control word reads back as it was written at the start, with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Global enable; must be 1 for a start |
| cfg_master | input | 1 | Master-mode select; must be 1 for a start |
| ctl_wr | input | 1 | Transfer control word write strobe |
| ctl_wdata | input | 32 | Transfer control word write data |
| ctl_rdata | output | 32 | Transfer control word read-back, bit 31 = go |
| burst_len | input | CNT_W | Byte count sampled at start |
| half_tick | input | 1 | Divider strobe, one per SPI half period |
| tx_empty | input | 1 | TX FIFO empty flag |
| tx_data | input | DATA_W | TX FIFO head entry |
| tx_pop | output | 1 | TX FIFO pop strobe |
| rx_push | output | 1 | RX FIFO push strobe |
| rx_data | output | DATA_W | Received byte, valid with `rx_push` |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 4 | Chip-select lines |

## Verification
The embedded properties cover the following on every cycle:
- the go bit against the done pulse and the enable inputs;
- the SPI clock resting at its polarity outside bursts;
- the one-active-line rule on `cs_out`;
- the active chip select under any SPI clock edge in automatic mode;
- no pop from an empty TX FIFO;
- frozen configuration while busy.

Only the directed scenarios can show end-to-end results, because they need a model slave that captures and replies bit by bit. These results are the byte values exchanged in each phase, polarity and bit-order combination, the exact edge and pop counts per burst, the resumption after a TX stall, and the zero-length burst.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int CS_LINES   = 4;
  localparam int CS_SEL_W   = 2;

  localparam int CTL_PHASE_B = 0;
  localparam int CTL_POL_B   = 1;
  localparam int CTL_CSLOW_B = 2;
  localparam int CTL_SEL_LO  = 4;
  localparam int CTL_SWOWN_B = 6;
  localparam int CTL_SWLVL_B = 7;
  localparam int CTL_LSB_B   = 12;
  localparam int CTL_GO_B    = 31;

  typedef struct packed {
    logic                lsb_first;
    logic                sw_lvl;
    logic                sw_own;
    logic [CS_SEL_W-1:0] cs_sel;
    logic                cs_low;
    logic                cpol;
    logic                cpha;
  } xfer_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LEAD  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_PUSH  = 3'd4,
    ST_TRAIL = 3'd5
  } eng_state_t;

  function automatic xfer_cfg_t unpack_cfg(input logic [31:0] w);
    xfer_cfg_t c;
    c.cpha      = w[CTL_PHASE_B];
    c.cpol      = w[CTL_POL_B];
    c.cs_low    = w[CTL_CSLOW_B];
    c.cs_sel    = w[CTL_SEL_LO +: CS_SEL_W];
    c.sw_own    = w[CTL_SWOWN_B];
    c.sw_lvl    = w[CTL_SWLVL_B];
    c.lsb_first = w[CTL_LSB_B];
    return c;
  endfunction

  function automatic logic [31:0] pack_ctl(input xfer_cfg_t c, input logic go);
    logic [31:0] w;
    w = '0;
    w[CTL_PHASE_B]               = c.cpha;
    w[CTL_POL_B]                 = c.cpol;
    w[CTL_CSLOW_B]               = c.cs_low;
    w[CTL_SEL_LO +: CS_SEL_W]    = c.cs_sel;
    w[CTL_SWOWN_B]               = c.sw_own;
    w[CTL_SWLVL_B]               = c.sw_lvl;
    w[CTL_LSB_B]                 = c.lsb_first;
    w[CTL_GO_B]                  = go;
    return w;
  endfunction

endpackage

// File: rtl/spi_ctl_reg.sv
module spi_ctl_reg
  import spi_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        en,
  input  logic        master,
  input  logic        burst_zero,
  input  logic        fin_evt,
  output xfer_cfg_t   cfg,
  output logic        go_q,
  output logic        start_evt,
  output logic [31:0] rdata
);

  logic write_ok;
  logic unused_wbits;

  assign write_ok     = wr && !go_q;
  assign start_evt    = write_ok && wdata[CTL_GO_B] && en && master;
  assign rdata        = pack_ctl(cfg, go_q);
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      go_q <= 1'b0;
    end else begin
      if (write_ok) cfg <= unpack_cfg(wdata);
      if (fin_evt)                      go_q <= 1'b0;
      else if (start_evt && !burst_zero) go_q <= 1'b1;
    end
  end

  // R1
  go_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(en && master));

  // R2
  go_clears_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_q) |-> $past(fin_evt));

  // R11
  cfg_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> $stable(cfg));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic              half_tick,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              miso,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk_tgl,
  output logic              mosi,
  output logic              cs_assert,
  output logic              fin_evt,
  output logic              done_q,
  output logic              edge_evt
);

  localparam int EDGE_N = 2 * DATA_W;
  localparam int EW     = $clog2(EDGE_N);
  localparam int BW     = $clog2(DATA_W);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGE_N - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  left_q;
  logic              first_q;
  logic [DATA_W-1:0] tx_byte;
  logic [DATA_W-1:0] rx_byte;
  logic [BW-1:0]     bidx;
  logic [EW-1:0]     eidx;
  logic              sample_evt;
  logic              advance_evt;
  logic [BW-1:0]     adv_idx;

  // Physical lane of logical bit k under the selected bit order.
  function automatic logic [BW-1:0] lane(input logic [BW-1:0] k, input logic lsb);
    return lsb ? k : BW'(DATA_W - 1) - k;
  endfunction

  // Logical bit index that becomes current after edge e.
  function automatic logic [BW-1:0] next_bit(input logic [EW-1:0] e, input logic ph);
    return ph ? e[EW-1:1] : e[EW-1:1] + BW'(1);
  endfunction

  assign edge_evt    = (state == ST_SHIFT) && half_tick;
  assign sample_evt  = edge_evt && (eidx[0] == cpha);
  assign advance_evt = edge_evt && (cpha ? !eidx[0] : (eidx[0] && eidx != LAST_EDGE));
  assign adv_idx     = next_bit(eidx, cpha);

  assign tx_pop    = (state == ST_FETCH) && !tx_empty;
  assign rx_push   = (state == ST_PUSH);
  assign rx_data   = rx_byte;
  assign mosi      = tx_byte[lane(bidx, lsb_first)];
  assign cs_assert = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_PUSH) ||
                     (state == ST_TRAIL) || ((state == ST_FETCH) && !first_q);
  assign fin_evt   = ((state == ST_TRAIL) && half_tick) ||
                     ((state == ST_IDLE) && start_evt && (burst_len == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      left_q   <= '0;
      first_q  <= 1'b0;
      tx_byte  <= '0;
      rx_byte  <= '0;
      bidx     <= '0;
      eidx     <= '0;
      sclk_tgl <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin_evt;
      case (state)
        ST_IDLE: begin
          if (start_evt && (burst_len != '0)) begin
            left_q  <= burst_len;
            first_q <= 1'b1;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (!tx_empty) begin
            tx_byte <= tx_data;
            rx_byte <= '0;
            bidx    <= '0;
            eidx    <= '0;
            state   <= first_q ? ST_LEAD : ST_SHIFT;
          end
        end
        ST_LEAD: begin
          if (half_tick) begin
            first_q <= 1'b0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (half_tick) begin
            sclk_tgl <= ~sclk_tgl;
            if (sample_evt) rx_byte[lane(eidx[EW-1:1], lsb_first)] <= miso;
            if (advance_evt) bidx <= adv_idx;
            if (eidx == LAST_EDGE) state <= ST_PUSH;
            else                   eidx  <= eidx + EW'(1);
          end
        end
        ST_PUSH: begin
          left_q <= left_q - CNT_W'(1);
          state  <= (left_q == CNT_W'(1)) ? ST_TRAIL : ST_FETCH;
        end
        ST_TRAIL: begin
          if (half_tick) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  // R4
  clock_rest_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SHIFT) |-> !sclk_tgl);

  // R3
  push_not_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !done_q);

endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive
  import spi_eng_pkg::*;
(
  input  xfer_cfg_t           cfg,
  input  logic                cs_assert,
  output logic [CS_LINES-1:0] cs_lines
);

  function automatic logic line_level(input logic picked, input xfer_cfg_t c,
                                      input logic act);
    if (!picked)  return c.cs_low;
    if (c.sw_own) return c.sw_lvl;
    return act ? ~c.cs_low : c.cs_low;
  endfunction

  for (genvar i = 0; i < CS_LINES; i++) begin : g_line
    assign cs_lines[i] = line_level(cfg.cs_sel == CS_SEL_W'(i), cfg, cs_assert);
  end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic                cfg_master,
  input  logic                ctl_wr,
  input  logic [31:0]         ctl_wdata,
  output logic [31:0]         ctl_rdata,
  input  logic [CNT_W-1:0]    burst_len,
  input  logic                half_tick,
  input  logic                tx_empty,
  input  logic [DATA_W-1:0]   tx_data,
  output logic                tx_pop,
  output logic                rx_push,
  output logic [DATA_W-1:0]   rx_data,
  output logic                xfer_done,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic [CS_LINES-1:0] cs_out
);

  xfer_cfg_t cfg;
  logic      go_q;
  logic      start_evt;
  logic      fin_evt;
  logic      sclk_tgl;
  logic      cs_assert;
  logic      edge_evt;

  spi_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (ctl_wr),
    .wdata      (ctl_wdata),
    .en         (cfg_enable),
    .master     (cfg_master),
    .burst_zero (burst_len == '0),
    .fin_evt    (fin_evt),
    .cfg        (cfg),
    .go_q       (go_q),
    .start_evt  (start_evt),
    .rdata      (ctl_rdata)
  );

  spi_shift_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .burst_len (burst_len),
    .half_tick (half_tick),
    .cpha      (cfg.cpha),
    .lsb_first (cfg.lsb_first),
    .tx_empty  (tx_empty),
    .tx_data   (tx_data),
    .tx_pop    (tx_pop),
    .miso      (miso),
    .rx_push   (rx_push),
    .rx_data   (rx_data),
    .sclk_tgl  (sclk_tgl),
    .mosi      (mosi),
    .cs_assert (cs_assert),
    .fin_evt   (fin_evt),
    .done_q    (xfer_done),
    .edge_evt  (edge_evt)
  );

  spi_cs_drive u_cs (
    .cfg       (cfg),
    .cs_assert (cs_assert),
    .cs_lines  (cs_out)
  );

  assign sclk = cfg.cpol ^ sclk_tgl;

  // R2
  done_sees_go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !go_q);

  // R4
  sclk_rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go_q |-> (sclk == cfg.cpol));

  // R7
  one_active_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_out ^ {CS_LINES{cfg.cs_low}}) <= 1);

  // R8
  edge_under_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && $past(go_q) && !cfg.sw_own && !$stable(sclk))
      |-> (cs_out[cfg.cs_sel] == ~cfg.cs_low));

endmodule

// File: tb/tb_spi_xfer_engine.sv
module tb_spi_xfer_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1;
  logic        cfg_master = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic [15:0] burst_len = '0;
  logic        half_tick = 1'b0;
  logic        tx_empty;
  logic [7:0]  tx_data;
  logic        tx_pop;
  logic        rx_push;
  logic [7:0]  rx_data;
  logic        xfer_done;
  logic        sclk;
  logic        mosi;
  logic        miso;
  logic [3:0]  cs_out;

  spi_xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .burst_len(burst_len), .half_tick(half_tick),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .xfer_done(xfer_done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // divider strobe every 3 clocks
  int div = 0;
  always @(posedge clk) begin
    div       <= (div == 2) ? 0 : div + 1;
    half_tick <= (div == 2);
  end

  // TX FIFO model, RX sink, done counter
  logic [7:0] txq   [0:15];
  logic [7:0] reply [0:15];
  logic [7:0] rx_got[0:15];
  logic [7:0] cap   [0:15];
  int  txq_n = 0;
  int  txq_rd = 0;
  int  rx_n = 0;
  int  done_cnt = 0;
  logic q_clr = 1'b0;

  assign tx_empty = (txq_rd >= txq_n);
  assign tx_data  = txq[txq_rd[3:0]];

  always @(posedge clk) begin
    if (q_clr) begin
      txq_rd <= 0; rx_n <= 0; done_cnt <= 0;
    end else begin
      if (tx_pop) txq_rd <= txq_rd + 1;
      if (rx_push) begin
        rx_got[rx_n[3:0]] <= rx_data;
        rx_n <= rx_n + 1;
      end
      if (xfer_done) done_cnt <= done_cnt + 1;
    end
  end

  // model slave and pin monitor
  logic m_cpha = 0, m_cpol = 0, m_lsb = 0, m_low = 0;
  int   m_sel = 0;
  logic [7:0] nsamp = 0;
  int   edge_cnt = 0, cs_viol = 0, oth_viol = 0, start_viol = 0;
  logic prev_sclk = 0;

  assign miso = reply[nsamp[6:3]][m_lsb ? nsamp[2:0] : ~nsamp[2:0]];

  always @(negedge clk) begin
    if (q_clr) begin
      nsamp = 0; edge_cnt = 0; cs_viol = 0; oth_viol = 0; start_viol = 0;
      prev_sclk = sclk;
    end else begin
      if (sclk !== prev_sclk) begin
        edge_cnt++;
        if (cs_out[m_sel] !== ~m_low) cs_viol++;
        if ((sclk != m_cpol) ^ m_cpha) begin
          if (nsamp < 128) cap[nsamp[6:3]][m_lsb ? nsamp[2:0] : ~nsamp[2:0]] = mosi;
          nsamp++;
        end
      end
      for (int k = 0; k < 4; k++)
        if (k != m_sel && cs_out[k] !== m_low) oth_viol++;
      if (xfer_done && ctl_rdata[31]) start_viol++;
      prev_sclk = sclk;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic ph, input logic pol, input logic low,
                                     input int sel, input logic sw, input logic lvl,
                                     input logic lsb, input logic go);
    logic [31:0] w = '0;
    w[0] = ph; w[1] = pol; w[2] = low; w[5:4] = sel[1:0];
    w[6] = sw; w[7] = lvl; w[12] = lsb; w[31] = go;
    return w;
  endfunction

  task automatic wr_ctl(input logic [31:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk); q_clr = 1'b1;
    @(negedge clk); @(negedge clk); q_clr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (done_cnt < 1 && t < 5000) begin @(negedge clk); t++; end
    chk(done_cnt >= 1, req, "done pulse seen", done_cnt, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic ph, input logic pol, input logic low,
                       input int sel, input logic lsb, input int n, input int seed);
    m_cpha = ph; m_cpol = pol; m_low = low; m_sel = sel; m_lsb = lsb;
    for (int i = 0; i < 16; i++) begin
      txq[i]   = 8'(8'hC3 ^ (seed * 11 + i * 7 + i * i * 13));
      reply[i] = 8'(8'h3C + seed * 17 + i * 53);
    end
    txq_n = n; burst_len = 16'(n);
    wr_ctl(mk(ph, pol, low, sel, 1'b0, 1'b0, lsb, 1'b0));
    clear_mon();
  endtask

  task automatic check_bytes(input int n, input string req);
    int bad_rx = 0, bad_tx = 0;
    for (int i = 0; i < n; i++) begin
      if (rx_got[i] !== reply[i]) bad_rx++;
      if (cap[i] !== txq[i]) bad_tx++;
    end
    chk(rx_n == n, req, "bytes pushed", rx_n, n);
    chk(bad_rx == 0, req, "received byte mismatches", bad_rx, 0);
    chk(bad_tx == 0, req, "sent byte mismatches", bad_tx, 0);
  endtask

  task automatic run_burst(input logic ph, input logic pol, input logic low,
                           input int sel, input logic lsb, input int n, input int seed);
    setup(ph, pol, low, sel, lsb, n, seed);
    wr_ctl(mk(ph, pol, low, sel, 1'b0, 1'b0, lsb, 1'b1));
    chk(ctl_rdata[31] == 1'b1, "R2", "go bit while running", int'(ctl_rdata[31]), 1);
    wait_done("R3");
    check_bytes(n, ph ? "R5/R6 phase1" : "R5/R6 phase0");
    chk(edge_cnt == 16 * n, "R4", "sclk edges", edge_cnt, 16 * n);
    chk(sclk == pol, "R4", "sclk rest level", int'(sclk), int'(pol));
    chk(txq_rd == n, "R3", "tx pops", txq_rd, n);
    chk(done_cnt == 1, "R3", "done pulses", done_cnt, 1);
    chk(start_viol == 0, "R2", "go set during done", start_viol, 0);
    chk(ctl_rdata[31] == 1'b0, "R2", "go bit after done", int'(ctl_rdata[31]), 0);
    chk(cs_viol == 0, "R8", "edges without select", cs_viol, 0);
    chk(cs_out[sel] == low, "R8", "select released", int'(cs_out[sel]), int'(low));
    chk(oth_viol == 0, "R7", "unselected line active", oth_viol, 0);
  endtask

  task automatic test_gate();
    setup(1'b0, 1'b0, 1'b1, 0, 1'b0, 2, 1);
    cfg_enable = 1'b0;
    wr_ctl(mk(1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b1));
    repeat (40) @(negedge clk);
    chk(ctl_rdata[31] == 1'b0, "R1", "go with enable low", int'(ctl_rdata[31]), 0);
    chk(txq_rd == 0 && edge_cnt == 0 && done_cnt == 0, "R1", "activity with enable low",
        txq_rd + edge_cnt + done_cnt, 0);
    cfg_enable = 1'b1; cfg_master = 1'b0;
    wr_ctl(mk(1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b1));
    repeat (40) @(negedge clk);
    chk(ctl_rdata[31] == 1'b0, "R1", "go with master low", int'(ctl_rdata[31]), 0);
    chk(txq_rd == 0 && edge_cnt == 0 && done_cnt == 0, "R1", "activity with master low",
        txq_rd + edge_cnt + done_cnt, 0);
    cfg_master = 1'b1;
  endtask

  task automatic test_zero();
    setup(1'b0, 1'b1, 1'b1, 1, 1'b0, 0, 2);
    wr_ctl(mk(1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b0, 1'b1));
    wait_done("R3");
    chk(done_cnt == 1, "R3", "zero-length done pulses", done_cnt, 1);
    chk(txq_rd == 0 && rx_n == 0, "R3", "zero-length pops+pushes", txq_rd + rx_n, 0);
    chk(edge_cnt == 0, "R3", "zero-length sclk edges", edge_cnt, 0);
    chk(start_viol == 0 && ctl_rdata[31] == 1'b0, "R2", "zero-length go bit",
        int'(ctl_rdata[31]), 0);
  endtask

  task automatic test_stall();
    int t = 0, e0;
    setup(1'b0, 1'b0, 1'b1, 2, 1'b0, 3, 3);
    txq_n = 1;
    wr_ctl(mk(1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b0, 1'b0, 1'b1));
    while (rx_n < 1 && t < 2000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    e0 = edge_cnt;
    repeat (40) @(negedge clk);
    chk(edge_cnt == e0, "R10", "edges during stall", edge_cnt - e0, 0);
    chk(sclk == 1'b0, "R10", "sclk parked in stall", int'(sclk), 0);
    chk(txq_rd == 1, "R10", "pops during stall", txq_rd, 1);
    chk(cs_out[2] == 1'b0, "R10", "select held in stall", int'(cs_out[2]), 0);
    txq_n = 3;
    wait_done("R10");
    check_bytes(3, "R10");
    chk(cs_viol == 0, "R8", "edges without select (stall)", cs_viol, 0);
  endtask

  task automatic test_busy_write();
    logic [31:0] orig;
    orig = mk(1'b1, 1'b0, 1'b0, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    setup(1'b1, 1'b0, 1'b0, 3, 1'b1, 2, 4);
    wr_ctl(orig | 32'h8000_0000);
    repeat (10) @(negedge clk);
    wr_ctl(mk(1'b0, 1'b1, 1'b1, 1, 1'b1, 1'b1, 1'b0, 1'b1));
    wait_done("R11");
    chk(ctl_rdata == orig, "R11", "control word after busy write", int'(ctl_rdata), int'(orig));
    check_bytes(2, "R11");
    chk(done_cnt == 1, "R11", "extra start while busy", done_cnt, 1);
  endtask

  task automatic test_sw_cs();
    m_low = 1'b0; m_sel = 2;
    wr_ctl(mk(1'b0, 1'b0, 1'b0, 2, 1'b1, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    chk(cs_out == 4'b0100, "R9", "sw level 1 active-high", int'(cs_out), 4);
    wr_ctl(mk(1'b0, 1'b0, 1'b0, 2, 1'b1, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    chk(cs_out == 4'b0000, "R9", "sw level 0 active-high", int'(cs_out), 0);
    wr_ctl(mk(1'b0, 1'b0, 1'b1, 1, 1'b1, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    chk(cs_out == 4'b1101, "R9", "sw level 0 active-low", int'(cs_out), 13);
    wr_ctl(mk(1'b0, 1'b0, 1'b1, 1, 1'b1, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    chk(cs_out == 4'b1111, "R9", "sw level 1 active-low", int'(cs_out), 15);
    wr_ctl(mk(1'b0, 1'b0, 1'b1, 3, 1'b0, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    chk(cs_out == 4'b1111, "R7", "auto idle active-low all inactive", int'(cs_out), 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_rdata == 32'h0, "R2", "reset control word", int'(ctl_rdata), 0);
    chk(sclk == 1'b0, "R4", "reset sclk", int'(sclk), 0);
    chk(cs_out == 4'b0000, "R7", "reset chip selects", int'(cs_out), 0);
    chk(!tx_pop && !rx_push && !xfer_done, "R3", "reset strobes",
        int'(tx_pop) + int'(rx_push) + int'(xfer_done), 0);

    test_gate();
    run_burst(1'b0, 1'b0, 1'b1, 0, 1'b0, 3, 5);
    run_burst(1'b1, 1'b0, 1'b0, 1, 1'b1, 4, 6);
    run_burst(1'b0, 1'b1, 1'b1, 2, 1'b1, 2, 7);
    run_burst(1'b1, 1'b1, 1'b1, 3, 1'b0, 3, 8);
    run_burst(1'b0, 1'b0, 1'b0, 1, 1'b0, 1, 9);
    test_zero();
    test_stall();
    test_busy_write();
    test_sw_cs();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule